// File: doc/BRIEF.md
# Signed-Digit Squaring Row Generator

This block takes an operand written in canonical signed-digit form, where each digit is -1, 0 or +1 and no two neighbouring digits are both nonzero. It returns a small set of rows whose sum is the square of that operand. With an operand of N digits (N a multiple of 4) it yields N/4 rows, and each row is 2N digits wide. Every row is itself canonical, so a later carry-free signed-digit adder tree can merge them cheaply. The block is purely combinational. Summing the rows, converting them to binary and checking the operand for validity belong to the logic around it.

The innermost four digits of the operand go to a gate-level squarer. Each wider shell of four more digits splits its span into a top pair, a middle run and a bottom pair. The squares of the two pairs land in the free ends of row 0. The three cross products are folded into one row of their own, built from shifts, sign swaps and a digitwise OR, because a canonical pair of digits never holds more than one nonzero digit. The block has no state machine and no states.

Top module: `csd_sq_ppgen`

## Requirements
- R1: Each digit occupies two bits, with the upper bit meaning +1 and the lower bit meaning -1: 00 is zero, 10 is +1 and 01 is -1. Digit k of the operand sits at operand[k] and digit d of row r sits at pp_rows[r][d]. The code 11 never appears on an output.
- R2: For every canonical operand, the N/4 rows, each read with digit d weighing 2^d, add up to the square of the operand's value.
- R3: No row ever holds two adjacent nonzero digits.
- R4: Across all rows and all canonical operands, exactly N(N+3)/4 digit positions can be nonzero. Row 0 digit N-3, the second digit of the inner 4-digit square, is always zero.
- R5: An operand with a single nonzero digit at position k, of either sign, gives +1 at row 0 digit 2k and zero in every other digit of every row.
- R6: Negating every digit of the operand leaves all rows unchanged.
- R7: Row 0 holds the square of the inner four digits together with the squares of the outer digit pairs. Row j (j at least 1) holds only the cross terms of the shell of width 4+4j, so when the outer digit pairs are zero, every row except row 0 is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | 2*N | Canonical signed-digit operand, N digits of two bits each |
| pp_rows | output | (N/4)*2N*2 | N/4 canonical rows of 2N digits whose sum is the square |

## Verification
The block has no stored state, so any fault in a shell's shift, sign swap or OR merge shows up at the ports on the same operand that excites it. It appears either as a row sum that differs from the square or as a pair of adjacent nonzero digits in one row. Sweeping every canonical 8-digit operand excites each placement case of the cross row: the top pair nonzero in its upper or lower digit, crossed with the same choice for the bottom pair. A digit placed at the wrong position shows up again in the count of positions that ever become active. Negating the operand and supplying one-hot operands expose sign handling that the square would otherwise hide.

// File: rtl/csd_sq_pkg.sv
package csd_sq_pkg;

    typedef struct packed {
        logic pos;
        logic neg;
    } sd_digit_t;

    function automatic logic sd_nz(sd_digit_t d);
        return d.pos | d.neg;
    endfunction

    function automatic sd_digit_t sd_flip(sd_digit_t d);
        sd_digit_t r;
        r.pos = d.neg;
        r.neg = d.pos;
        return r;
    endfunction

    function automatic sd_digit_t sd_or(sd_digit_t a, sd_digit_t b);
        return sd_digit_t'(a | b);
    endfunction

    function automatic logic sd_same(sd_digit_t a, sd_digit_t b);
        return sd_nz(a) && (a == b);
    endfunction

    function automatic logic sd_opp(sd_digit_t a, sd_digit_t b);
        return sd_nz(a) && sd_nz(b) && (a != b);
    endfunction

    // digit times digit
    function automatic sd_digit_t sd_prod(sd_digit_t a, sd_digit_t b);
        sd_digit_t r;
        r.pos = sd_same(a, b);
        r.neg = sd_opp(a, b);
        return r;
    endfunction

    // digit scaled by a sign digit: keep, swap or clear
    function automatic sd_digit_t sd_scale(sd_digit_t d, sd_digit_t s);
        if (s.pos)      return d;
        else if (s.neg) return sd_flip(d);
        else            return sd_digit_t'(2'b00);
    endfunction

endpackage

// File: rtl/csd_sq_base4.sv
module csd_sq_base4
    import csd_sq_pkg::*;
(
    input  sd_digit_t [3:0] x,
    output sd_digit_t [7:0] z
);

    always_comb begin
        z = '0;
        z[0].pos = sd_nz(x[0]);
        z[2].pos = sd_nz(x[1]);
        z[3].pos = sd_opp(x[2], x[0]);
        z[3].neg = sd_same(x[2], x[0]);
        z[4].pos = sd_same(x[3], x[0]) | (sd_nz(x[2]) & ~sd_nz(x[0]));
        z[4].neg = sd_opp(x[3], x[0]);
        z[5].pos = sd_opp(x[3], x[1]) | sd_same(x[2], x[0]);
        z[5].neg = sd_same(x[3], x[1]);
        z[6].pos = sd_nz(x[3]) & ~sd_nz(x[1]);
        z[7].pos = sd_same(x[3], x[1]);
    end

    always_comb begin
        for (int k = 0; k < 8; k++) begin
            AST_BASE_LEGAL: assert (!(z[k].pos && z[k].neg)); // R1
        end
        for (int k = 0; k < 7; k++) begin
            AST_BASE_NO_ADJ: assert (!(sd_nz(z[k]) && sd_nz(z[k+1]))); // R3
        end
        AST_BASE_IDLE_DIGIT: assert (!sd_nz(z[1])); // R4
    end

endmodule

// File: rtl/csd_sq_cross.sv
module csd_sq_cross
    import csd_sq_pkg::*;
#(
    parameter int W = 8
) (
    input  sd_digit_t [1:0]     top,
    input  sd_digit_t [W-5:0]   mid,
    input  sd_digit_t [1:0]     low,
    output sd_digit_t [2*W-1:0] z
);

    localparam int MW = W - 4;
    localparam int ZW = 2 * W;

    sd_digit_t [ZW-1:0] t_tm;
    sd_digit_t [ZW-1:0] t_tl;
    sd_digit_t [ZW-1:0] t_ml;

    // 2*T*M*2^W, 2*T*L*2^(W-2), 2*M*L*4
    always_comb begin
        t_tm = '0;
        t_tl = '0;
        t_ml = '0;
        for (int i = 0; i < MW; i++) begin
            t_tm[W+1+i] = sd_or(t_tm[W+1+i], sd_scale(mid[i], top[0]));
            t_tm[W+2+i] = sd_or(t_tm[W+2+i], sd_scale(mid[i], top[1]));
            t_ml[3+i]   = sd_or(t_ml[3+i],   sd_scale(mid[i], low[0]));
            t_ml[4+i]   = sd_or(t_ml[4+i],   sd_scale(mid[i], low[1]));
        end
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                t_tl[W-1+a+b] = sd_or(t_tl[W-1+a+b], sd_prod(top[a], low[b]));
            end
        end
    end

    always_comb begin
        for (int k = 0; k < ZW; k++) begin
            z[k] = sd_or(sd_or(t_tm[k], t_tl[k]), t_ml[k]);
        end
    end

    always_comb begin
        for (int k = 0; k < ZW; k++) begin
            AST_CROSS_DISJOINT: assert ((32'(sd_nz(t_tm[k])) + 32'(sd_nz(t_tl[k])) + 32'(sd_nz(t_ml[k]))) <= 32'd1); // R2
        end
        for (int k = 0; k < ZW - 1; k++) begin
            AST_CROSS_NO_ADJ: assert (!(sd_nz(z[k]) && sd_nz(z[k+1]))); // R3
        end
    end

endmodule

// File: rtl/csd_sq_ppgen.sv
module csd_sq_ppgen
    import csd_sq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0][1:0]             operand,
    output logic [N/4-1:0][2*N-1:0][1:0]  pp_rows
);

    localparam int ROWS     = N / 4;
    localparam int OUTD     = 2 * N;
    localparam int BASE_OFF = (N - 4) / 2;

    if ((N < 4) || ((N % 4) != 0)) begin : g_bad_width
        $error("csd_sq_ppgen: N must be a positive multiple of 4");
    end

    sd_digit_t [N-1:0]             x;
    sd_digit_t [ROWS-1:0][OUTD-1:0] rows;
    sd_digit_t [7:0]               base_sq;
    sd_digit_t [OUTD-1:0]          row0;

    assign x = operand;

    csd_sq_base4 u_base (
        .x (x[BASE_OFF+3:BASE_OFF]),
        .z (base_sq)
    );

    // row 0: inner square plus the pair squares of every shell
    always_comb begin
        row0 = '0;
        for (int j = 0; j < 8; j++) begin
            row0[2*BASE_OFF+j] = base_sq[j];
        end
        for (int lv = 1; lv < ROWS; lv++) begin
            AST_ROW0_LOW_FREE: assert (!(sd_nz(x[(N-4-4*lv)/2]) && sd_nz(row0[N-4-4*lv]))); // R7
            row0[N-4-4*lv].pos     = row0[N-4-4*lv].pos     | sd_nz(x[(N-4-4*lv)/2]);
            row0[N-4-4*lv+2].pos   = row0[N-4-4*lv+2].pos   | sd_nz(x[(N-4-4*lv)/2+1]);
            AST_ROW0_TOP_FREE: assert (!(sd_nz(x[(N+4+4*lv)/2-1]) && sd_nz(row0[N+4+4*lv-2]))); // R7
            row0[N+4+4*lv-4].pos   = row0[N+4+4*lv-4].pos   | sd_nz(x[(N+4+4*lv)/2-2]);
            row0[N+4+4*lv-2].pos   = row0[N+4+4*lv-2].pos   | sd_nz(x[(N+4+4*lv)/2-1]);
        end
    end

    assign rows[0] = row0;

    for (genvar lv = 1; lv < ROWS; lv++) begin : g_shell
        localparam int W = 4 + 4 * lv;
        localparam int O = (N - W) / 2;

        sd_digit_t [2*W-1:0] cz;
        sd_digit_t [OUTD-1:0] lrow;

        csd_sq_cross #(.W(W)) u_cross (
            .top (x[O+W-1:O+W-2]),
            .mid (x[O+W-3:O+2]),
            .low (x[O+1:O]),
            .z   (cz)
        );

        always_comb begin
            lrow = '0;
            for (int j = 0; j < 2*W; j++) begin
                lrow[2*O+j] = cz[j];
            end
        end

        assign rows[lv] = lrow;
    end

    assign pp_rows = rows;

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            for (int k = 0; k < OUTD; k++) begin
                AST_ROW_LEGAL: assert (!(rows[r][k].pos && rows[r][k].neg)); // R1
            end
            for (int k = 0; k < OUTD - 1; k++) begin
                AST_ROW_NO_ADJ: assert (!(sd_nz(rows[r][k]) && sd_nz(rows[r][k+1]))); // R3
            end
        end
    end

endmodule

// File: tb/tb_csd_sq_ppgen.sv
module tb_csd_sq_ppgen;

    localparam int N    = 8;
    localparam int ROWS = N / 4;
    localparam int D    = 2 * N;
    localparam int NV   = 8;

    logic clk = 1'b0;
    logic rst_n;
    always #5 clk = ~clk;

    logic [N-1:0][1:0]          op;
    logic [ROWS-1:0][D-1:0][1:0] rows;

    csd_sq_ppgen #(.N(N)) dut (
        .operand (op),
        .pp_rows (rows)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [ROWS-1:0][D-1:0] seen;

    // operand encodings (pos bit high) and their squares
    localparam logic [15:0] VOP [NV] = '{16'h0000, 16'h0002, 16'h0001, 16'h8000,
                                         16'h2222, 16'h1111, 16'h2121, 16'h4848};
    localparam longint      VSQ [NV] = '{0, 1, 1, 16384, 7225, 7225, 2601, 10404};

    function automatic longint op_value(logic [N-1:0][1:0] v);
        longint s = 0;
        for (int i = 0; i < N; i++) begin
            if (v[i] == 2'b10) s += (longint'(1) << i);
            if (v[i] == 2'b01) s -= (longint'(1) << i);
        end
        return s;
    endfunction

    function automatic longint rows_value(logic [ROWS-1:0][D-1:0][1:0] r);
        longint s = 0;
        for (int j = 0; j < ROWS; j++) begin
            for (int i = 0; i < D; i++) begin
                if (r[j][i] == 2'b10) s += (longint'(1) << i);
                if (r[j][i] == 2'b01) s -= (longint'(1) << i);
            end
        end
        return s;
    endfunction

    function automatic bit rows_canonical(logic [ROWS-1:0][D-1:0][1:0] r);
        bit ok = 1'b1;
        for (int j = 0; j < ROWS; j++) begin
            for (int i = 0; i < D - 1; i++) begin
                if ((r[j][i] != 2'b00) && (r[j][i+1] != 2'b00)) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    function automatic int illegal_codes(logic [ROWS-1:0][D-1:0][1:0] r);
        int c = 0;
        for (int j = 0; j < ROWS; j++) begin
            for (int i = 0; i < D; i++) begin
                if (r[j][i] == 2'b11) c++;
            end
        end
        return c;
    endfunction

    function automatic logic [N-1:0][1:0] negate(logic [N-1:0][1:0] v);
        logic [N-1:0][1:0] r;
        for (int i = 0; i < N; i++) r[i] = {v[i][0], v[i][1]};
        return r;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(logic [N-1:0][1:0] v);
        @(negedge clk);
        op = v;
        @(posedge clk);
        #1;
        for (int j = 0; j < ROWS; j++) begin
            for (int i = 0; i < D; i++) begin
                if (rows[j][i] != 2'b00) seen[j][i] = 1'b1;
            end
        end
    endtask

    task automatic full_check(logic [N-1:0][1:0] v);
        logic [ROWS-1:0][D-1:0][1:0] first;
        longint val;
        apply(v);
        val = op_value(v);
        check(rows_value(rows) == val * val, "R2 row sum", rows_value(rows), val * val);
        check(rows_canonical(rows), "R3 adjacency", 0, 1);
        check(illegal_codes(rows) == 0, "R1 code 11", illegal_codes(rows), 0);
        if ((v[7] == 2'b00) && (v[6] == 2'b00) && (v[1] == 2'b00) && (v[0] == 2'b00)) begin
            check(rows[1] == '0, "R7 shell row idle", longint'(rows[1]), 0);
        end
        first = rows;
        apply(negate(v));
        check(rows == first, "R6 negation", longint'(rows), longint'(first));
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL R2 watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [ROWS-1:0][D-1:0][1:0] want;
        int active;
        seen  = '0;
        rst_n = 1'b0;
        op    = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        check(rows == '0, "R2 reset zero operand", longint'(rows), 0);

        // table walk
        for (int t = 0; t < NV; t++) begin
            apply(VOP[t]);
            check(rows_value(rows) == VSQ[t], "R2 table", rows_value(rows), VSQ[t]);
            check(rows_canonical(rows), "R3 table", 0, 1);
        end

        // every canonical operand
        for (int c = 0; c < 6561; c++) begin
            logic [N-1:0][1:0] v;
            int t;
            bit canon;
            t = c;
            for (int i = 0; i < N; i++) begin
                v[i] = (t % 3 == 1) ? 2'b10 : ((t % 3 == 2) ? 2'b01 : 2'b00);
                t = t / 3;
            end
            canon = 1'b1;
            for (int i = 0; i < N - 1; i++) begin
                if ((v[i] != 2'b00) && (v[i+1] != 2'b00)) canon = 1'b0;
            end
            if (canon) full_check(v);
        end

        active = 0;
        for (int j = 0; j < ROWS; j++) begin
            for (int i = 0; i < D; i++) active += int'(seen[j][i]);
        end
        check(active == N * (N + 3) / 4, "R4 active count", active, N * (N + 3) / 4);
        check(seen[0][N-3] == 1'b0, "R4 inner idle digit", seen[0][N-3], 0);

        // one-hot operands of both signs
        for (int k = 0; k < N; k++) begin
            for (int s = 0; s < 2; s++) begin
                logic [N-1:0][1:0] v;
                v = '0;
                v[k] = (s == 0) ? 2'b10 : 2'b01;
                apply(v);
                want = '0;
                want[0][2*k] = 2'b10;
                check(rows == want, "R5 one-hot", longint'(rows), longint'(want));
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule